// File: doc/BRIEF.md
# Post-increment load/store execution unit

This unit executes one 64-bit integer load or store at a time. Memory is always accessed at the base register value exactly as it was read. Only after the access completes is the base register rewritten with the base plus an offset. The offset is either a sign-extended immediate or the value of an index register. A caller presents an operation descriptor together with the operand values and register numbers. The unit issues a valid/ready memory request and, for a load, formats the returned data. It then asserts the writebacks for the data register and the base register in one cycle.

A load whose base register number is zero, or matches its destination register number, is an invalid form. The unit raises a one-cycle flag for it and does nothing else. Control is a five-state machine:
- `ST_IDLE` accepts an operation. It goes to `ST_FLAG` for an invalid form and to `ST_REQ` otherwise.
- `ST_FLAG` raises the flag and returns to `ST_IDLE`.
- `ST_REQ` holds the request until it is taken, then goes to `ST_WAIT`.
- `ST_WAIT` waits for the response or acknowledge and captures the read data, then goes to `ST_DONE`.
- `ST_DONE` pulses the writebacks and returns to `ST_IDLE`.

Top module: `pinc_lsu`

## Requirements
- R1: `op_ready` is high only in the idle state. An operation is taken on a cycle with `op_valid` and `op_ready` both high. `op_valid` is ignored at all other times.
- R2: `mem_addr` equals the `base_val` presented with the accepted operation, with no offset added. The request holds `mem_req_valid`, address and data stable until `mem_req_ready` is seen.
- R3: For the base writeback, the indexed form gives `base_val + index_val`. The immediate form gives `base_val` plus `imm_val` sign-extended to 64 bits.
- R4: For a doubleword (`op_size` = 3) in immediate form, the two low bits of `imm_val` are replaced by zeros before sign-extension.
- R5: Size codes are 0 byte, 1 halfword, 2 word and 3 doubleword. A zero-extending load places the low 8, 16 or 32 bits of `mem_rdata` in the destination and clears every higher bit. A doubleword load passes all 64 bits through.
- R6: With `op_signed` set, halfword and word loads sign-extend to 64 bits. For byte and doubleword loads, `op_signed` has no effect.
- R7: A store drives `mem_we` = 1 and `mem_size` = the size code. `mem_wdata` carries the low 8, 16, 32 or 64 bits of `store_val`, with higher bits zero. A load drives `mem_we` = 0.
- R8: A load with `op_base_reg` = 0, or with `op_base_reg` = `op_data_reg`, raises `bad_form` for exactly the cycle after acceptance. It issues no request and no writeback, and `op_ready` returns on the next cycle. Stores are never flagged.
- R9: Writebacks are asserted for exactly one cycle, the cycle after `mem_rsp_valid` is seen while waiting. A load asserts both writebacks; a store asserts only the base writeback. The writebacks carry the latched register numbers.
- R10: After reset, `op_ready` is high, and the request, flag and writeback outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation can be taken |
| op_is_store | input | 1 | 1 store, 0 load |
| op_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| op_signed | input | 1 | Algebraic (sign-extending) load |
| op_indexed | input | 1 | Offset from index register instead of immediate |
| op_data_reg | input | 5 | Destination (load) or source (store) register number |
| op_base_reg | input | 5 | Base register number |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| imm_val | input | 16 | Immediate offset field |
| store_val | input | 64 | Store source register value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Access address |
| mem_we | output | 1 | Write request |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Store data, right-justified |
| mem_rsp_valid | input | 1 | Read data or store acknowledge |
| mem_rdata | input | 64 | Read data, right-justified |
| bad_form | output | 1 | Invalid load form detected |
| data_wb_en | output | 1 | Data register write enable |
| data_wb_reg | output | 5 | Data register number |
| data_wb_val | output | 64 | Loaded value |
| base_wb_en | output | 1 | Base register write enable |
| base_wb_reg | output | 5 | Base register number |
| base_wb_val | output | 64 | Updated base value |

## Verification
The assertions take the memory side to be well behaved:
- `mem_rsp_valid` arrives only after a request has been taken.
- Read data is right-justified for the requested size.
- Addresses are naturally aligned.

The properties also assume that operand inputs need only be valid in the accept cycle. The stimulus answers each request exactly once, after a chosen number of ready and response delay cycles. While the unit is busy, the stimulus offers scrambled operands and a raised `op_valid`. It drops `op_valid` before the unit returns to idle, so only intended operations are accepted.

// File: rtl/pinc_lsu_pkg.sv
package pinc_lsu_pkg;

    // Access size codes; the numeric value is the log2 of the byte count.
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FLAG = 3'd1,
        ST_REQ  = 3'd2,
        ST_WAIT = 3'd3,
        ST_DONE = 3'd4
    } lsu_state_e;

endpackage

// File: rtl/pinc_lsu_offset.sv
// Post-access base update: base plus index, or base plus sign-extended immediate.
module pinc_lsu_offset
    import pinc_lsu_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int IMM_BITS = 16,
    parameter int DW_SCALE = 2
) (
    input  logic [XLEN-1:0]     base,
    input  logic [XLEN-1:0]     index,
    input  logic [IMM_BITS-1:0] imm,
    input  logic                indexed,
    input  acc_size_e           size,
    output logic [XLEN-1:0]     next_base
);

    localparam int EXT_BITS = XLEN - IMM_BITS;

    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] offset;

    always_comb begin
        imm_sx = {{EXT_BITS{imm[IMM_BITS-1]}}, imm};
        // Doubleword immediate form: scaled field, low bits forced to zero.
        if (size == SZ_DWORD && !indexed) begin
            imm_sx[DW_SCALE-1:0] = '0;
        end
        offset    = indexed ? index : imm_sx;
        next_base = base + offset;
    end

endmodule

// File: rtl/pinc_lsu_fmt.sv
// Size-dependent formatting of load results and store data.
module pinc_lsu_fmt
    import pinc_lsu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NSIZES = 4
) (
    input  acc_size_e       size,
    input  logic            signed_ld,
    input  logic [XLEN-1:0] rdata,
    input  logic [XLEN-1:0] sdata,
    output logic [XLEN-1:0] load_val,
    output logic [XLEN-1:0] store_val
);

    logic [XLEN-1:0] ld_opt [NSIZES];
    logic [XLEN-1:0] st_opt [NSIZES];

    for (genvar g = 0; g < NSIZES; g++) begin : g_lane
        localparam int W = 8 << g;
        if (W >= XLEN) begin : g_full
            assign ld_opt[g] = rdata;
            assign st_opt[g] = sdata;
        end else begin : g_part
            // Algebraic loading exists only for halfword and word.
            localparam bit ALG = (g == 1) || (g == 2);
            logic fill;
            assign fill      = ALG && signed_ld && rdata[W-1];
            assign ld_opt[g] = {{(XLEN-W){fill}}, rdata[W-1:0]};
            assign st_opt[g] = {{(XLEN-W){1'b0}}, sdata[W-1:0]};
        end
    end

    assign load_val  = ld_opt[size];
    assign store_val = st_opt[size];

endmodule

// File: rtl/pinc_lsu_ctrl.sv
// Sequencing of one operation: accept, request, wait, writeback.
module pinc_lsu_ctrl
    import pinc_lsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic op_bad,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    output logic op_ready,
    output logic take_op,
    output logic capture,
    output logic mem_req_valid,
    output logic bad_form,
    output logic wb_fire
);

    lsu_state_e state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (op_valid) state_nx = op_bad ? ST_FLAG : ST_REQ;
            ST_FLAG: state_nx = ST_IDLE;
            ST_REQ:  if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        op_ready      = 1'b0;
        mem_req_valid = 1'b0;
        bad_form      = 1'b0;
        wb_fire       = 1'b0;
        capture       = 1'b0;
        unique case (state)
            ST_IDLE: op_ready      = 1'b1;
            ST_FLAG: bad_form      = 1'b1;
            ST_REQ:  mem_req_valid = 1'b1;
            ST_WAIT: capture       = mem_rsp_valid;
            ST_DONE: wb_fire       = 1'b1;
            default: op_ready      = 1'b0;
        endcase
        take_op = op_ready && op_valid && !op_bad;
    end

endmodule

// File: rtl/pinc_lsu.sv
module pinc_lsu
    import pinc_lsu_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int REG_BITS = 5,
    parameter int IMM_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    output logic                op_ready,
    input  logic                op_is_store,
    input  logic [1:0]          op_size,
    input  logic                op_signed,
    input  logic                op_indexed,
    input  logic [REG_BITS-1:0] op_data_reg,
    input  logic [REG_BITS-1:0] op_base_reg,
    input  logic [XLEN-1:0]     base_val,
    input  logic [XLEN-1:0]     index_val,
    input  logic [IMM_BITS-1:0] imm_val,
    input  logic [XLEN-1:0]     store_val,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [XLEN-1:0]     mem_addr,
    output logic                mem_we,
    output logic [1:0]          mem_size,
    output logic [XLEN-1:0]     mem_wdata,
    input  logic                mem_rsp_valid,
    input  logic [XLEN-1:0]     mem_rdata,
    output logic                bad_form,
    output logic                data_wb_en,
    output logic [REG_BITS-1:0] data_wb_reg,
    output logic [XLEN-1:0]     data_wb_val,
    output logic                base_wb_en,
    output logic [REG_BITS-1:0] base_wb_reg,
    output logic [XLEN-1:0]     base_wb_val
);

    acc_size_e           size_in;
    acc_size_e           size_q;
    logic                op_bad;
    logic                take_op;
    logic                capture;
    logic                wb_fire;
    logic [XLEN-1:0]     next_base;
    logic [XLEN-1:0]     addr_q;
    logic [XLEN-1:0]     nbase_q;
    logic [XLEN-1:0]     store_q;
    logic [XLEN-1:0]     rdata_q;
    logic                signed_q;
    logic                is_store_q;
    logic [REG_BITS-1:0] dreg_q;
    logic [REG_BITS-1:0] breg_q;
    logic [XLEN-1:0]     load_fmt;
    logic [XLEN-1:0]     store_fmt;

    assign size_in = acc_size_e'(op_size);

    // Invalid load form: base is register zero, or base aliases the destination.
    assign op_bad = !op_is_store &&
                    ((op_base_reg == '0) || (op_base_reg == op_data_reg));

    pinc_lsu_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_bad        (op_bad),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .op_ready      (op_ready),
        .take_op       (take_op),
        .capture       (capture),
        .mem_req_valid (mem_req_valid),
        .bad_form      (bad_form),
        .wb_fire       (wb_fire)
    );

    pinc_lsu_offset #(
        .XLEN     (XLEN),
        .IMM_BITS (IMM_BITS)
    ) u_offset (
        .base      (base_val),
        .index     (index_val),
        .imm       (imm_val),
        .indexed   (op_indexed),
        .size      (size_in),
        .next_base (next_base)
    );

    pinc_lsu_fmt #(
        .XLEN (XLEN)
    ) u_fmt (
        .size      (size_q),
        .signed_ld (signed_q),
        .rdata     (rdata_q),
        .sdata     (store_q),
        .load_val  (load_fmt),
        .store_val (store_fmt)
    );

    // Operand capture at acceptance; the access address is the raw base.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            nbase_q    <= '0;
            store_q    <= '0;
            size_q     <= SZ_BYTE;
            signed_q   <= 1'b0;
            is_store_q <= 1'b0;
            dreg_q     <= '0;
            breg_q     <= '0;
        end else if (take_op) begin
            addr_q     <= base_val;
            nbase_q    <= next_base;
            store_q    <= store_val;
            size_q     <= size_in;
            signed_q   <= op_signed;
            is_store_q <= op_is_store;
            dreg_q     <= op_data_reg;
            breg_q     <= op_base_reg;
        end
    end

    // Response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= mem_rdata;
        end
    end

    assign mem_addr    = addr_q;
    assign mem_we      = is_store_q;
    assign mem_size    = size_q;
    assign mem_wdata   = store_fmt;

    assign data_wb_en  = wb_fire && !is_store_q;
    assign data_wb_reg = dreg_q;
    assign data_wb_val = load_fmt;
    assign base_wb_en  = wb_fire;
    assign base_wb_reg = breg_q;
    assign base_wb_val = nbase_q;

endmodule

// File: rtl/pinc_lsu_chk.sv
module pinc_lsu_chk #(
    parameter int XLEN     = 64,
    parameter int REG_BITS = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic                op_ready,
    input logic                op_is_store,
    input logic [REG_BITS-1:0] op_base_reg,
    input logic [XLEN-1:0]     base_val,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic [XLEN-1:0]     mem_addr,
    input logic [XLEN-1:0]     mem_wdata,
    input logic                bad_form,
    input logic                data_wb_en,
    input logic                base_wb_en
);

    // R1
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !mem_req_valid && !base_wb_en && !bad_form);

    // R2
    addr_is_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && op_is_store |=> mem_req_valid && (mem_addr == $past(base_val)));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_wdata));

    // R8
    bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && !op_is_store && (op_base_reg == '0) |=> bad_form);

    // R8
    bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |-> !mem_req_valid && !data_wb_en && !base_wb_en);

    // R9
    data_with_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wb_en |-> base_wb_en);

    // R9
    wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wb_en |=> !base_wb_en && op_ready);

endmodule

bind pinc_lsu pinc_lsu_chk #(
    .XLEN     (XLEN),
    .REG_BITS (REG_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_ready      (op_ready),
    .op_is_store   (op_is_store),
    .op_base_reg   (op_base_reg),
    .base_val      (base_val),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .bad_form      (bad_form),
    .data_wb_en    (data_wb_en),
    .base_wb_en    (base_wb_en)
);

// File: tb/pinc_lsu_test.sv
`timescale 1ns/1ps
module pinc_lsu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic        op_is_store = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic        op_signed = 1'b0;
    logic        op_indexed = 1'b0;
    logic [4:0]  op_data_reg = 5'd0;
    logic [4:0]  op_base_reg = 5'd0;
    logic [63:0] base_val = '0;
    logic [63:0] index_val = '0;
    logic [15:0] imm_val = '0;
    logic [63:0] store_val = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_addr;
    logic        mem_we;
    logic [1:0]  mem_size;
    logic [63:0] mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        bad_form;
    logic        data_wb_en;
    logic [4:0]  data_wb_reg;
    logic [63:0] data_wb_val;
    logic        base_wb_en;
    logic [4:0]  base_wb_reg;
    logic [63:0] base_wb_val;

    always #2.5 clk = ~clk;

    pinc_lsu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_is_store(op_is_store), .op_size(op_size), .op_signed(op_signed),
        .op_indexed(op_indexed), .op_data_reg(op_data_reg), .op_base_reg(op_base_reg),
        .base_val(base_val), .index_val(index_val), .imm_val(imm_val),
        .store_val(store_val), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rdata(mem_rdata), .bad_form(bad_form), .data_wb_en(data_wb_en),
        .data_wb_reg(data_wb_reg), .data_wb_val(data_wb_val),
        .base_wb_en(base_wb_en), .base_wb_reg(base_wb_reg), .base_wb_val(base_wb_val)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // Behavioural reference: 0 idle, 1 flagged, 2 requesting, 3 waiting, 4 writeback.
    int          ph;
    logic [63:0] m_base, m_index, m_store, m_rdata;
    logic [15:0] m_imm;
    logic [1:0]  m_size;
    logic        m_sgn, m_st, m_idx;
    logic [4:0]  m_dreg, m_breg;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= 0;
        end else begin
            case (ph)
                0: if (op_valid) begin
                    m_base <= base_val;  m_index <= index_val; m_store <= store_val;
                    m_imm  <= imm_val;   m_size  <= op_size;   m_sgn   <= op_signed;
                    m_st   <= op_is_store; m_idx <= op_indexed;
                    m_dreg <= op_data_reg; m_breg <= op_base_reg;
                    if (!op_is_store && (op_base_reg == 0 || op_base_reg == op_data_reg))
                        ph <= 1;
                    else
                        ph <= 2;
                end
                1: ph <= 0;
                2: if (mem_req_ready) ph <= 3;
                3: if (mem_rsp_valid) begin m_rdata <= mem_rdata; ph <= 4; end
                default: ph <= 0;
            endcase
        end
    end

    function automatic logic [63:0] exp_base();
        longint s;
        s = longint'($signed(m_imm));
        if (m_size == 2'd3 && !m_idx) s = s & ~longint'(3);
        return m_base + (m_idx ? m_index : 64'(s));
    endfunction

    function automatic logic [63:0] exp_load();
        case (m_size)
            2'd0: return m_rdata & 64'hFF;
            2'd1: return m_sgn ? 64'(longint'($signed(m_rdata[15:0]))) : (m_rdata & 64'hFFFF);
            2'd2: return m_sgn ? 64'(longint'($signed(m_rdata[31:0]))) : (m_rdata & 64'hFFFF_FFFF);
            default: return m_rdata;
        endcase
    endfunction

    function automatic logic [63:0] exp_wdata();
        if (m_size == 2'd3) return m_store;
        return m_store & ((64'd1 << (8 << m_size)) - 64'd1);
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            chk("R1", "op_ready", 64'(op_ready), 64'(ph == 0));
            chk("R2", "mem_req_valid", 64'(mem_req_valid), 64'(ph == 2));
            chk("R8", "bad_form", 64'(bad_form), 64'(ph == 1));
            chk("R9", "base_wb_en", 64'(base_wb_en), 64'(ph == 4));
            chk("R9", "data_wb_en", 64'(data_wb_en), 64'(ph == 4 && !m_st));
            if (ph == 2) begin
                chk("R2", "mem_addr", mem_addr, m_base);
                chk("R7", "mem_we", 64'(mem_we), 64'(m_st));
                chk("R7", "mem_size", 64'(mem_size), 64'(m_size));
                if (m_st) chk("R7", "mem_wdata", mem_wdata, exp_wdata());
            end
            if (ph == 4) begin
                chk("R9", "base_wb_reg", 64'(base_wb_reg), 64'(m_breg));
                chk((m_size == 2'd3 && !m_idx) ? "R4" : "R3", "base_wb_val",
                    base_wb_val, exp_base());
                if (!m_st) begin
                    chk("R9", "data_wb_reg", 64'(data_wb_reg), 64'(m_dreg));
                    chk((m_sgn && (m_size == 2'd1 || m_size == 2'd2)) ? "R6" : "R5",
                        "data_wb_val", data_wb_val, exp_load());
                end
            end
        end
    end

    task automatic scramble();
        op_is_store = 1'($urandom); op_size = 2'($urandom); op_signed = 1'($urandom);
        op_indexed = 1'($urandom); op_data_reg = 5'($urandom); op_base_reg = 5'($urandom);
        base_val = {$urandom, $urandom}; index_val = {$urandom, $urandom};
        imm_val = 16'($urandom); store_val = {$urandom, $urandom};
    endtask

    task automatic run_op(input logic st, input logic [1:0] sz, input logic sg,
                          input logic ix, input logic [4:0] dreg, input logic [4:0] breg,
                          input logic [63:0] base, input logic [63:0] index,
                          input logic [15:0] imm, input logic [63:0] sval,
                          input logic [63:0] rdata, input int rdy_dly, input int rsp_dly);
        logic bad;
        bad = !st && (breg == 0 || breg == dreg);
        @(posedge clk); #1;
        op_valid = 1'b1; op_is_store = st; op_size = sz; op_signed = sg; op_indexed = ix;
        op_data_reg = dreg; op_base_reg = breg; base_val = base; index_val = index;
        imm_val = imm; store_val = sval;
        @(posedge clk); #1;
        if (bad) begin
            op_valid = 1'b0;
            scramble();
            repeat (2) begin @(posedge clk); #1; end
        end else begin
            // Busy: offered operations must be ignored (R1).
            scramble();
            repeat (rdy_dly) begin @(posedge clk); #1; end
            mem_req_ready = 1'b1;
            @(posedge clk); #1;
            mem_req_ready = 1'b0;
            repeat (rsp_dly) begin @(posedge clk); #1; end
            mem_rsp_valid = 1'b1; mem_rdata = rdata; op_valid = 1'b0;
            @(posedge clk); #1;
            mem_rsp_valid = 1'b0; mem_rdata = {$urandom, $urandom};
            @(posedge clk); #1;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL R9 watchdog actual=running expected=complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "op_ready after reset", 64'(op_ready), 64'd1);
        chk("R10", "request after reset", 64'(mem_req_valid), 64'd0);
        chk("R10", "writeback after reset", 64'(base_wb_en | data_wb_en | bad_form), 64'd0);

        // R5 zero-extending byte, immediate
        run_op(0, 2'd0, 0, 0, 5'd3, 5'd4, 64'h1000, 64'h0, 16'h0001, 0, 64'hFFFF_FFFF_FFFF_FF80, 0, 0);
        // R5 halfword, indexed (R3)
        run_op(0, 2'd1, 0, 1, 5'd5, 5'd6, 64'h2000, 64'h40, 16'h7777, 0, 64'h1234_5678_9ABC_8001, 2, 1);
        // R6 halfword algebraic negative, negative immediate
        run_op(0, 2'd1, 1, 0, 5'd7, 5'd8, 64'h3000, 64'h0, 16'hFFFE, 0, 64'h0000_0000_0000_8001, 1, 3);
        // R6 halfword algebraic positive
        run_op(0, 2'd1, 1, 0, 5'd9, 5'd10, 64'h3100, 64'h0, 16'h0002, 0, 64'hFFFF_FFFF_FFFF_7FFF, 0, 0);
        // R5 word zero-extend
        run_op(0, 2'd2, 0, 0, 5'd11, 5'd12, 64'h4000, 64'h0, 16'h0004, 0, 64'hDEAD_BEEF_CAFE_F00D, 0, 2);
        // R6 word algebraic, indexed negative index
        run_op(0, 2'd2, 1, 1, 5'd13, 5'd14, 64'h5000, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0, 0, 64'h0000_0000_8000_0000, 3, 0);
        // R4 doubleword immediate with low field bits set
        run_op(0, 2'd3, 0, 0, 5'd15, 5'd16, 64'h6000, 64'h0, 16'h000B, 0, 64'hA5A5_5A5A_0F0F_F0F0, 0, 1);
        // R4 doubleword negative immediate
        run_op(0, 2'd3, 0, 0, 5'd17, 5'd18, 64'h6100, 64'h0, 16'hFFF7, 0, 64'h8000_0000_0000_0001, 1, 0);
        // R6 signed flag ignored for byte and doubleword
        run_op(0, 2'd0, 1, 0, 5'd19, 5'd20, 64'h7000, 64'h0, 16'h0001, 0, 64'h0000_0000_0000_00F0, 0, 0);
        run_op(0, 2'd3, 1, 1, 5'd21, 5'd22, 64'h7100, 64'h8, 16'h0, 0, 64'hF000_0000_0000_0000, 0, 0);
        // R7 stores of every size
        run_op(1, 2'd0, 0, 0, 5'd1, 5'd2, 64'h8000, 64'h0, 16'h0001, 64'h1122_3344_5566_7788, 0, 0, 1);
        run_op(1, 2'd1, 0, 1, 5'd3, 5'd2, 64'h8100, 64'h2, 16'h0, 64'h1122_3344_5566_7788, 0, 2, 0);
        run_op(1, 2'd2, 0, 0, 5'd4, 5'd5, 64'h8200, 64'h0, 16'hFFFC, 64'hFFFF_FFFF_8765_4321, 0, 1, 1);
        run_op(1, 2'd3, 0, 0, 5'd6, 5'd7, 64'h8300, 64'h0, 16'h0013, 64'hFEDC_BA98_7654_3210, 0, 0, 0);
        // R8 stores with base register zero are not flagged
        run_op(1, 2'd2, 0, 0, 5'd6, 5'd0, 64'h8400, 64'h0, 16'h0010, 64'h55, 0, 0, 0);
        // R8 invalid load forms
        run_op(0, 2'd2, 0, 0, 5'd6, 5'd0, 64'h9000, 64'h0, 16'h0004, 0, 0, 0, 0);
        run_op(0, 2'd0, 0, 1, 5'd9, 5'd9, 64'h9100, 64'h4, 16'h0, 0, 0, 0, 0);
        // R2 long request stall, R9 long response wait
        run_op(0, 2'd2, 0, 1, 5'd23, 5'd24, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 16'h0, 0, 64'h7FFF_FFFF, 6, 5);

        repeat (3) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule